// File: doc/BRIEF.md
# PCI Bus-Master Acquisition Sequencer

This block is the front end a PCI bus master uses to take ownership of the bus. An internal DMA engine presents a transfer request made up of a transfer kind and a start address. The block records the request and asserts the active-low bus request line. It then waits for the arbiter's active-low grant. A grant alone is not enough to start a cycle, because another master may still be moving data when it arrives. The block therefore also waits until both FRAME and IRDY are sampled high, which means the bus is idle. It then issues a one-clock address phase. In that clock it drives the address, a PCI command code and FRAME, all valid together, with no address stepping. In the same clock it pulses a start strobe to the data-phase logic.

The transfer kind selects the command:
- Memory Read for initialization-block reads, descriptor reads and single transmit-buffer reads.
- Memory Write for descriptor and receive-buffer writes.
- For burst transmit-buffer reads, a configuration input chooses Memory Read Line or Memory Read Multiple.

Separate output enables for AD, C/BE and FRAME are raised only during the address-phase clock. As a result the block never drives the shared bus while another master owns it.

Top module: `pci_bus_acquire`

## Requirements
- R1: A synchronous active-low reset leaves `req_n` and `frame_n_out` at 1, and `ad_oe`, `cbe_oe`, `frame_oe`, `addr_start` and `dma_ack` at 0.
- R2: In the idle state, a high `dma_req` is accepted. `dma_ack` is high in that same clock, and `req_n` is low from the next clock.
- R3: The address phase starts only in the clock after one in which the block was waiting for the bus and sampled `gnt_n`=0, `frame_n_in`=1 and `irdy_n_in`=1. Before that, `frame_n_out` stays 1.
- R4: If `gnt_n` is sampled high while the block is waiting for the bus to go idle, the block returns to waiting for grant. `req_n` stays low and no address phase starts.
- R5: The address phase lasts exactly one clock. In that clock `frame_n_out`=0, all three output enables are 1, `addr_start`=1, `ad_out` carries the accepted address and `cbe_out` carries the command.
- R6: Kinds 0 (initialization or descriptor read) and 2 (single transmit-buffer read) give command 4'b0110. Kind 1 (descriptor or receive-buffer write) gives 4'b0111.
- R7: Kind 3 (burst transmit-buffer read) gives 4'b1100 when `burst_line` is 0 and 4'b1110 when it is 1. `burst_line` is sampled when the request is accepted.
- R8: In the address-phase clock, `req_n` is 1 unless `dma_req` is high. In that case the new request is acknowledged in the same clock, `req_n` stays 0, and the block goes back to waiting for grant.
- R9: Whenever `cbe_oe` is 1, `cbe_out` is one of 4'b0110, 4'b0111, 4'b1100 or 4'b1110.
- R10: Outside the address-phase clock, all three output enables and `addr_start` are 0 and `frame_n_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_req | input | 1 | DMA transfer request, held until acknowledged |
| dma_kind | input | 2 | Transfer kind, 0 to 3 as in R6 and R7 |
| dma_addr | input | AW | Transfer start address |
| burst_line | input | 1 | Burst read command select: 1 gives Memory Read Line, 0 gives Memory Read Multiple |
| dma_ack | output | 1 | Request accepted at this clock edge |
| req_n | output | 1 | Bus request to the arbiter, active low |
| gnt_n | input | 1 | Bus grant from the arbiter, active low |
| frame_n_in | input | 1 | Sampled FRAME on the bus |
| irdy_n_in | input | 1 | Sampled IRDY on the bus |
| ad_out | output | AW | Address driven in the address phase |
| ad_oe | output | 1 | Output enable for AD |
| cbe_out | output | 4 | Command driven in the address phase |
| cbe_oe | output | 1 | Output enable for C/BE |
| frame_n_out | output | 1 | FRAME driven by this master, active low |
| frame_oe | output | 1 | Output enable for FRAME |
| addr_start | output | 1 | One-clock strobe to the data-phase logic |

## Verification
The bench builds the block with its default 32-bit address width. This is the width the PCI AD bus requires, so random addresses exercise every address bit in the address phase. Directed cases cover the paths that random traffic rarely combines:
- a grant that arrives while the bus is busy;
- a grant that is withdrawn while the block waits for idle;
- a request held through the address phase;
- both burst command choices.

After these, thousands of random cycles mix grant, bus activity and request timing.

// File: rtl/pci_bus_acquire.sv
module pci_bus_acquire #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_req,
  input  logic [1:0]    dma_kind,
  input  logic [AW-1:0] dma_addr,
  input  logic          burst_line,
  output logic          dma_ack,
  output logic          req_n,
  input  logic          gnt_n,
  input  logic          frame_n_in,
  input  logic          irdy_n_in,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  output logic [3:0]    cbe_out,
  output logic          cbe_oe,
  output logic          frame_n_out,
  output logic          frame_oe,
  output logic          addr_start
);
  localparam logic [3:0] CMD_MR  = 4'b0110;
  localparam logic [3:0] CMD_MW  = 4'b0111;
  localparam logic [3:0] CMD_MRM = 4'b1100;
  localparam logic [3:0] CMD_MRL = 4'b1110;

  typedef enum logic [1:0] {IDLE, REQ_WAIT, BUS_WAIT, ADDR} state_t;

  state_t        state, state_nx;
  logic [AW-1:0] addr_q;
  logic [3:0]    cmd_q, cmd_sel;
  logic          bus_idle, in_addr;

  assign bus_idle = frame_n_in && irdy_n_in;
  assign in_addr  = (state == ADDR);
  assign dma_ack  = dma_req && (state == IDLE || in_addr);

  always_comb begin
    case (dma_kind)
      2'd1:    cmd_sel = CMD_MW;
      2'd3:    cmd_sel = burst_line ? CMD_MRL : CMD_MRM;
      default: cmd_sel = CMD_MR;
    endcase
  end

  always_comb begin
    state_nx = state;
    case (state)
      IDLE:     if (dma_ack) state_nx = REQ_WAIT;
      REQ_WAIT: if (!gnt_n) state_nx = BUS_WAIT;
      BUS_WAIT: if (gnt_n) state_nx = REQ_WAIT;
                else if (bus_idle) state_nx = ADDR;
      ADDR:     state_nx = dma_ack ? REQ_WAIT : IDLE;
      default:  state_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      addr_q <= '0;
      cmd_q  <= CMD_MR;
    end else begin
      state <= state_nx;
      if (dma_ack) begin
        addr_q <= dma_addr;
        cmd_q  <= cmd_sel;
      end
    end
  end

  assign req_n       = !(state == REQ_WAIT || state == BUS_WAIT || (in_addr && dma_req));
  assign ad_oe       = in_addr;
  assign cbe_oe      = in_addr;
  assign frame_oe    = in_addr;
  assign frame_n_out = !in_addr;
  assign addr_start  = in_addr;
  assign ad_out      = in_addr ? addr_q : '0;
  assign cbe_out     = in_addr ? cmd_q : 4'b0000;

  AST_FRAME_AFTER_IDLE_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n_out |-> ($past(!gnt_n) && $past(frame_n_in) && $past(irdy_n_in))); // R3
  AST_FRAME_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n_out |-> $past(!req_n)); // R3
  AST_ONE_CLOCK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_start |=> !addr_start); // R5
  AST_GNT_LOSS_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && frame_n_out && gnt_n) |=> (frame_n_out && !req_n)); // R4
  AST_LEGAL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cbe_oe |-> (cbe_out == CMD_MR || cbe_out == CMD_MW || cbe_out == CMD_MRM || cbe_out == CMD_MRL)); // R9
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_start && !dma_req) |-> req_n); // R8
  AST_ACK_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |=> !req_n); // R2
endmodule

// File: tb/pci_bus_acquire_bench.sv
module pci_bus_acquire_bench;
  localparam int AW = 32;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic dma_req = 0, burst_line = 0;
  logic [1:0] dma_kind = 0;
  logic [AW-1:0] dma_addr = '0;
  logic gnt_n = 1, frame_n_in = 1, irdy_n_in = 1;
  logic dma_ack, req_n, ad_oe, cbe_oe, frame_n_out, frame_oe, addr_start;
  logic [AW-1:0] ad_out;
  logic [3:0] cbe_out;

  int checks = 0, fails = 0, cyc = 0;
  int ph = 0;
  logic [AW-1:0] e_addr = '0;
  logic [3:0] e_cmd = 4'b0110;
  logic auto = 0;

  pci_bus_acquire #(.AW(AW)) u_pci_bus_acquire (
    .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_kind(dma_kind), .dma_addr(dma_addr),
    .burst_line(burst_line), .dma_ack(dma_ack), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_n_out(frame_n_out), .frame_oe(frame_oe),
    .addr_start(addr_start));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [3:0] exp_cmd(input logic [1:0] k, input logic line);
    case (k)
      2'd1: return 4'b0111;
      2'd3: return line ? 4'b1110 : 4'b1100;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic logic exp_acc();
    return dma_req && (ph == 0 || ph == 3);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) ph <= 0;
    else begin
      if (exp_acc()) begin
        e_addr <= dma_addr;
        e_cmd  <= exp_cmd(dma_kind, burst_line);
      end
      case (ph)
        0: if (exp_acc()) ph <= 1;
        1: if (!gnt_n) ph <= 2;
        2: if (gnt_n) ph <= 1; else if (frame_n_in && irdy_n_in) ph <= 3;
        default: ph <= exp_acc() ? 1 : 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_req_n;
      logic a;
      a = (ph == 3);
      exp_req_n = !(ph == 1 || ph == 2 || (a && dma_req));
      chk(dma_ack == exp_acc(), "R2 ack", AW'(dma_ack), AW'(exp_acc()));
      chk(req_n == exp_req_n, a ? "R8 req_n" : (ph == 2 ? "R4 req_n" : "R2 req_n"),
          AW'(req_n), AW'(exp_req_n));
      chk(frame_n_out == !a, a ? "R5 frame" : "R3 frame", AW'(frame_n_out), AW'(!a));
      chk({ad_oe, cbe_oe, frame_oe, addr_start} == {4{a}}, a ? "R5 enables" : "R10 enables",
          AW'({ad_oe, cbe_oe, frame_oe, addr_start}), AW'({4{a}}));
      if (a) begin
        chk(ad_out == e_addr, "R5 address", ad_out, e_addr);
        chk(cbe_out == e_cmd, e_cmd[3] ? "R7 command" : "R6 command", AW'(cbe_out), AW'(e_cmd));
      end
      if (cbe_oe)
        chk(cbe_out inside {4'b0110, 4'b0111, 4'b1100, 4'b1110}, "R9 legal", AW'(cbe_out), AW'(e_cmd));
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic set_req(input logic [1:0] k, input logic [AW-1:0] ad, input logic line);
    dma_req = 1; dma_kind = k; dma_addr = ad; burst_line = line;
  endtask

  task automatic wait_addr();
    for (int i = 0; i < 50 && frame_n_out; i++) step(1);
  endtask

  always @(negedge clk) begin
    if (auto && rst_n) begin
      #2;
      if (dma_req && frame_n_out && ph != 0) begin
      end else if (!dma_req || (dma_ack === 1'b0 && ph == 0)) begin
        if (!dma_req && ($urandom % 4 == 0))
          set_req(2'($urandom), $urandom, 1'($urandom));
      end
      gnt_n = ($urandom % 3 == 0);
      frame_n_in = ($urandom % 3 == 0) ? 1'b0 : 1'b1;
      irdy_n_in = ($urandom % 4 == 0) ? 1'b0 : 1'b1;
    end
  end

  always @(posedge clk) begin
    if (auto && rst_n && exp_acc()) begin
      #1;
      if ($urandom % 3 == 0) set_req(2'($urandom), $urandom, 1'($urandom));
      else dma_req = 0;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0;
    step(3);
    chk(req_n === 1'b1 && frame_n_out === 1'b1, "R1 idle lines", AW'({req_n, frame_n_out}), AW'(2'b11));
    chk({ad_oe, cbe_oe, frame_oe, addr_start, dma_ack} === 5'b0, "R1 enables",
        AW'({ad_oe, cbe_oe, frame_oe, addr_start, dma_ack}), '0);
    rst_n = 1;
    step(2);

    // R3: grant while bus busy, then idle
    set_req(2'd0, 32'h1000_0040, 0);
    step(1); dma_req = 0;
    step(2);
    gnt_n = 0; frame_n_in = 0; irdy_n_in = 0;
    step(3);
    chk(frame_n_out == 1'b1, "R3 busy hold", AW'(frame_n_out), 1);
    frame_n_in = 1; step(1);
    chk(frame_n_out == 1'b1, "R3 irdy busy", AW'(frame_n_out), 1);
    irdy_n_in = 1;
    wait_addr();
    chk(cbe_out == 4'b0110 && ad_out == 32'h1000_0040, "R6 kind0 read", AW'(cbe_out), 32'h6);
    step(2);

    // R4: grant removed while waiting for idle
    gnt_n = 1;
    set_req(2'd1, 32'hABCD_0000, 0);
    step(1); dma_req = 0;
    gnt_n = 0; frame_n_in = 0;
    step(2);
    gnt_n = 1; step(1);
    gnt_n = 1; frame_n_in = 1; step(2);
    chk(req_n == 1'b0 && frame_n_out == 1'b1, "R4 regrant wait", AW'({req_n, frame_n_out}), AW'(2'b01));
    gnt_n = 0;
    wait_addr();
    chk(cbe_out == 4'b0111, "R6 write", AW'(cbe_out), 32'h7);
    step(2);

    // R7/R8: back-to-back bursts, request held through address phase
    set_req(2'd3, 32'h0000_0100, 0);
    step(1);
    set_req(2'd3, 32'h0000_0200, 1);
    wait_addr();
    chk(cbe_out == 4'b1100 && req_n == 1'b0, "R8 burst mrm held", AW'({req_n, cbe_out}), AW'(5'b01100));
    step(1); dma_req = 0;
    wait_addr();
    chk(cbe_out == 4'b1110 && req_n == 1'b1, "R7 burst mrl", AW'({req_n, cbe_out}), AW'(5'b11110));

    // R6: single transmit read
    step(1);
    set_req(2'd2, 32'hFFFF_FFFC, 1);
    step(1); dma_req = 0;
    wait_addr();
    chk(cbe_out == 4'b0110, "R6 kind2 read", AW'(cbe_out), 32'h6);
    step(2);

    auto = 1;
    step(6000);
    auto = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule